// File: doc/BRIEF.md
# Multi-Cycle 16-bit Load/Store Processor

A non-pipelined processor core with 32 general registers of 16 bits and a fixed 32-bit instruction word. Instruction and data storage are two separate internal arrays. Every instruction takes exactly five clock cycles: fetch, decode with operand read, execute, memory, and write-back. Instructions that do not touch data memory still spend the memory cycle idle.

The program is written into instruction storage through a load port, normally while the core is held in reset. After reset is released the core runs from address zero. Three observation buses let the surrounding logic follow execution: the current PC and phase, the register write-back bus, and the data store bus.

Instruction formats. Register form: opcode[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6], funct[5:0]. Immediate form: opcode, rs, rt, imm[15:0], with rt as the destination. Jump form: opcode[31:26], target[25:0]. The jump address is target shifted left by two and cut to the PC width.

Top module: `risc16_core`

## Requirements
- R1: While rst_ni is low, pc_o is 0, phase_o is 0, and wb_en_o and st_en_o are 0. Register contents read as 0 after reset.
- R2: phase_o steps 0 (fetch), 1 (decode), 2 (execute), 3 (memory), 4 (write-back) and wraps to 0. Every instruction occupies exactly five cycles.
- R3: Opcode 0x00 with funct 0x20/0x22/0x24/0x25/0x26 writes rd with rs+rt, rs-rt, rs AND rt, rs OR rt, rs XOR rt, all modulo 2^16.
- R4: Opcode 0x00 with funct 0x00 writes rd with rs shifted left by shamt (0..31), and funct 0x02 writes rd with rs shifted right logically by shamt. A shift of 16 or more gives 0.
- R5: Opcode 0x08 writes rt with rs plus the sign-extended 16-bit immediate.
- R6: Opcode 0x23 writes rt with the data word at address (rs + sign-extended imm) modulo 64.
- R7: Opcode 0x2B raises st_en_o in the memory phase, with st_addr_o = (rs + sign-extended imm) modulo 64 and st_data_o = rt. A later load from that address returns this value.
- R8: Register 0 always reads as 0. A write addressed to it still shows on the write bus but leaves the register unchanged.
- R9: The PC changes only at the end of write-back. Any instruction other than a jump advances it by 4.
- R10: Opcode 0x02 sets the PC to target<<2, cut to 16 bits.
- R11: Opcode 0x03 sets the PC to the jump instruction's own address plus target<<2, modulo 2^16.
- R12: An unrecognised opcode writes no register, stores nothing, and advances the PC by 4.
- R13: wb_en_o is high only in the write-back phase, for instructions that write a register. In that phase wb_addr_o is the destination and wb_data_o is the value written. st_en_o is high only in the memory phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| prog_we_i | input | 1 | Instruction storage write enable |
| prog_addr_i | input | IMEM_AW | Instruction word index to write |
| prog_data_i | input | 32 | Instruction word to write |
| pc_o | output | PC_W | Address of the instruction in flight |
| phase_o | output | 3 | Current phase, 0 to 4 |
| wb_en_o | output | 1 | Register write in this cycle |
| wb_addr_o | output | 5 | Destination register |
| wb_data_o | output | DATA_W | Value written |
| st_en_o | output | 1 | Data store in this cycle |
| st_addr_o | output | DMEM_AW | Data word address of the store |
| st_data_o | output | DATA_W | Data stored |

## Verification
Two things happen in the final cycle of every instruction: the register write-back and the PC update. A wrong destination, a stale operand or a wrong next PC can therefore all appear in that one cycle. The bench provokes this by running a load that is immediately followed by an instruction that reads the loaded register, by writing register 0 and then reading it, and by relative and absolute jumps placed around instructions that must be skipped. It judges each write-back cycle against an instruction-level model. It then checks pc_o in the following instruction's memory cycle, so a wrong PC, or a skipped instruction that leaks a write, shows up as a mismatch.

// File: rtl/risc16_pkg.sv
package risc16_pkg;
  localparam int INSN_W = 32;
  localparam int RIDX_W = 5;
  localparam int TGT_W  = 26;

  localparam logic [5:0] OP_RTYPE = 6'h00;
  localparam logic [5:0] OP_JABS  = 6'h02;
  localparam logic [5:0] OP_JREL  = 6'h03;
  localparam logic [5:0] OP_ADDI  = 6'h08;
  localparam logic [5:0] OP_LOAD  = 6'h23;
  localparam logic [5:0] OP_STORE = 6'h2B;

  localparam logic [5:0] FN_SLL = 6'h00;
  localparam logic [5:0] FN_SRL = 6'h02;
  localparam logic [5:0] FN_ADD = 6'h20;
  localparam logic [5:0] FN_SUB = 6'h22;
  localparam logic [5:0] FN_AND = 6'h24;
  localparam logic [5:0] FN_OR  = 6'h25;
  localparam logic [5:0] FN_XOR = 6'h26;

  typedef enum logic [2:0] {
    PH_FETCH  = 3'd0,
    PH_DECODE = 3'd1,
    PH_EXEC   = 3'd2,
    PH_MEM    = 3'd3,
    PH_WB     = 3'd4
  } phase_e;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_XOR, ALU_SLL, ALU_SRL
  } alu_op_e;

  typedef enum logic [1:0] {PC_SEQ, PC_ABS, PC_REL} pc_sel_e;

  typedef struct packed {
    logic              reg_we;
    logic [RIDX_W-1:0] dst;
    logic              use_imm;
    alu_op_e           alu_op;
    logic              mem_rd;
    logic              mem_wr;
    pc_sel_e           pc_sel;
  } ctrl_t;
endpackage

// File: rtl/risc16_decoder.sv
module risc16_decoder
  import risc16_pkg::*;
(
  input  logic [INSN_W-1:0] insn_i,
  output ctrl_t             ctrl_o
);
  logic [5:0]        op, fn;
  logic [RIDX_W-1:0] rt, rd;

  assign op = insn_i[31:26];
  assign rt = insn_i[20:16];
  assign rd = insn_i[15:11];
  assign fn = insn_i[5:0];

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.alu_op  = ALU_ADD;
    ctrl_o.pc_sel  = PC_SEQ;
    ctrl_o.dst     = rt;
    case (op)
      OP_RTYPE: begin
        ctrl_o.dst    = rd;
        ctrl_o.reg_we = 1'b1;
        case (fn)
          FN_ADD:  ctrl_o.alu_op = ALU_ADD;
          FN_SUB:  ctrl_o.alu_op = ALU_SUB;
          FN_AND:  ctrl_o.alu_op = ALU_AND;
          FN_OR:   ctrl_o.alu_op = ALU_OR;
          FN_XOR:  ctrl_o.alu_op = ALU_XOR;
          FN_SLL:  ctrl_o.alu_op = ALU_SLL;
          FN_SRL:  ctrl_o.alu_op = ALU_SRL;
          default: ctrl_o.reg_we = 1'b0;
        endcase
      end
      OP_ADDI: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
      end
      OP_LOAD: begin
        ctrl_o.reg_we  = 1'b1;
        ctrl_o.use_imm = 1'b1;
        ctrl_o.mem_rd  = 1'b1;
      end
      OP_STORE: begin
        ctrl_o.use_imm = 1'b1;
        ctrl_o.mem_wr  = 1'b1;
      end
      OP_JABS: ctrl_o.pc_sel = PC_ABS;
      OP_JREL: ctrl_o.pc_sel = PC_REL;
      default: ;
    endcase
  end
endmodule

// File: rtl/risc16_regfile.sv
module risc16_regfile #(
  parameter int NREG   = 32,
  parameter int DATA_W = 16
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [$clog2(NREG)-1:0] ra_i,
  input  logic [$clog2(NREG)-1:0] rb_i,
  output logic [DATA_W-1:0]       rd_a_o,
  output logic [DATA_W-1:0]       rd_b_o,
  input  logic                    we_i,
  input  logic [$clog2(NREG)-1:0] wa_i,
  input  logic [DATA_W-1:0]       wd_i
);
  localparam int AW = $clog2(NREG);

  logic [DATA_W-1:0] regs [NREG];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < NREG; i++) regs[i] <= '0;
    end else if (we_i && wa_i != AW'(0)) begin
      regs[wa_i] <= wd_i;
    end
  end

  // register 0 is hard zero on both ports
  assign rd_a_o = (ra_i == AW'(0)) ? '0 : regs[ra_i];
  assign rd_b_o = (rb_i == AW'(0)) ? '0 : regs[rb_i];
endmodule

// File: rtl/risc16_alu.sv
module risc16_alu
  import risc16_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [4:0]        shamt_i,
  input  alu_op_e           op_i,
  output logic [DATA_W-1:0] y_o
);
  always_comb begin
    case (op_i)
      ALU_ADD: y_o = a_i + b_i;
      ALU_SUB: y_o = a_i - b_i;
      ALU_AND: y_o = a_i & b_i;
      ALU_OR:  y_o = a_i | b_i;
      ALU_XOR: y_o = a_i ^ b_i;
      ALU_SLL: y_o = a_i << shamt_i;
      ALU_SRL: y_o = a_i >> shamt_i;
      default: y_o = '0;
    endcase
  end
endmodule

// File: rtl/risc16_pc_unit.sv
module risc16_pc_unit
  import risc16_pkg::*;
#(
  parameter int PC_W = 16
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            commit_i,
  input  pc_sel_e         sel_i,
  input  logic [PC_W-3:0] tgt_i,
  output logic [PC_W-1:0] pc_o
);
  logic [PC_W-1:0] pc_q, jaddr, pc_nxt;

  assign jaddr = {tgt_i, 2'b00};

  always_comb begin
    case (sel_i)
      PC_ABS:  pc_nxt = jaddr;
      PC_REL:  pc_nxt = pc_q + jaddr;
      default: pc_nxt = pc_q + PC_W'(4);
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       pc_q <= '0;
    else if (commit_i) pc_q <= pc_nxt;
  end

  assign pc_o = pc_q;
endmodule

// File: rtl/risc16_core.sv
module risc16_core
  import risc16_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int PC_W    = 16,
  parameter int IMEM_AW = 6,
  parameter int DMEM_AW = 6
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               prog_we_i,
  input  logic [IMEM_AW-1:0] prog_addr_i,
  input  logic [INSN_W-1:0]  prog_data_i,
  output logic [PC_W-1:0]    pc_o,
  output logic [2:0]         phase_o,
  output logic               wb_en_o,
  output logic [RIDX_W-1:0]  wb_addr_o,
  output logic [DATA_W-1:0]  wb_data_o,
  output logic               st_en_o,
  output logic [DMEM_AW-1:0] st_addr_o,
  output logic [DATA_W-1:0]  st_data_o
);
  localparam int IMEM_WORDS = 1 << IMEM_AW;
  localparam int DMEM_WORDS = 1 << DMEM_AW;
  localparam int NREG       = 1 << RIDX_W;

  typedef logic [DATA_W-1:0] word_t;

  phase_e            phase_q;
  logic [INSN_W-1:0] ir_q;
  word_t             a_q, b_q, alu_q, mdr_q;
  word_t             rf_a, rf_b, op_b, alu_y, wb_val;
  word_t             imm_sx;
  ctrl_t             ctrl;
  logic [PC_W-1:0]   pc;

  logic [INSN_W-1:0] imem [IMEM_WORDS];
  word_t             dmem [DMEM_WORDS];

  // phase sequencer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) phase_q <= PH_FETCH;
    else begin
      case (phase_q)
        PH_FETCH:  phase_q <= PH_DECODE;
        PH_DECODE: phase_q <= PH_EXEC;
        PH_EXEC:   phase_q <= PH_MEM;
        PH_MEM:    phase_q <= PH_WB;
        default:   phase_q <= PH_FETCH;
      endcase
    end
  end

  // instruction storage, loaded through the program port
  always_ff @(posedge clk_i) begin
    if (prog_we_i) imem[prog_addr_i] <= prog_data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                ir_q <= '0;
    else if (phase_q == PH_FETCH) ir_q <= imem[pc[IMEM_AW+1:2]];
  end

  risc16_decoder u_dec (
    .insn_i (ir_q),
    .ctrl_o (ctrl)
  );

  risc16_regfile #(.NREG(NREG), .DATA_W(DATA_W)) u_rf (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .ra_i   (ir_q[25:21]),
    .rb_i   (ir_q[20:16]),
    .rd_a_o (rf_a),
    .rd_b_o (rf_b),
    .we_i   (phase_q == PH_WB && ctrl.reg_we),
    .wa_i   (ctrl.dst),
    .wd_i   (wb_val)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      a_q <= '0;
      b_q <= '0;
    end else if (phase_q == PH_DECODE) begin
      a_q <= rf_a;
      b_q <= rf_b;
    end
  end

  assign imm_sx = word_t'($signed(ir_q[15:0]));
  assign op_b   = ctrl.use_imm ? imm_sx : b_q;

  risc16_alu #(.DATA_W(DATA_W)) u_alu (
    .a_i     (a_q),
    .b_i     (op_b),
    .shamt_i (ir_q[10:6]),
    .op_i    (ctrl.alu_op),
    .y_o     (alu_y)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 alu_q <= '0;
    else if (phase_q == PH_EXEC) alu_q <= alu_y;
  end

  // data storage: load captures, store writes, both in the memory phase
  always_ff @(posedge clk_i) begin
    if (phase_q == PH_MEM && ctrl.mem_wr) dmem[alu_q[DMEM_AW-1:0]] <= b_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                mdr_q <= '0;
    else if (phase_q == PH_MEM && ctrl.mem_rd) mdr_q <= dmem[alu_q[DMEM_AW-1:0]];
  end

  assign wb_val = ctrl.mem_rd ? mdr_q : alu_q;

  risc16_pc_unit #(.PC_W(PC_W)) u_pc (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .commit_i (phase_q == PH_WB),
    .sel_i    (ctrl.pc_sel),
    .tgt_i    (ir_q[PC_W-3:0]),
    .pc_o     (pc)
  );

  assign pc_o      = pc;
  assign phase_o   = phase_q;
  assign wb_en_o   = (phase_q == PH_WB) && ctrl.reg_we;
  assign wb_addr_o = ctrl.dst;
  assign wb_data_o = wb_val;
  assign st_en_o   = (phase_q == PH_MEM) && ctrl.mem_wr;
  assign st_addr_o = alu_q[DMEM_AW-1:0];
  assign st_data_o = b_q;
endmodule

// File: rtl/risc16_core_chk.sv
module risc16_core_chk #(
  parameter int PC_W = 16
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic [PC_W-1:0] pc_o,
  input logic [2:0]      phase_o,
  input logic            wb_en_o,
  input logic            st_en_o
);
  p_phase_step_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o < 3'd4) |=> (phase_o == 3'($past(phase_o) + 3'd1)));

  p_phase_wrap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o == 3'd4) |=> (phase_o == 3'd0));

  p_pc_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (phase_o != 3'd4) |=> $stable(pc_o));

  p_pc_align_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pc_o[1:0] == 2'b00);

  p_wb_phase_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wb_en_o |-> (phase_o == 3'd4));

  p_st_phase_r13: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_en_o |-> (phase_o == 3'd3));
endmodule

bind risc16_core risc16_core_chk #(.PC_W(PC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .pc_o    (pc_o),
  .phase_o (phase_o),
  .wb_en_o (wb_en_o),
  .st_en_o (st_en_o)
);

// File: tb/risc16_core_tb.sv
module risc16_core_tb;
  localparam int CLK_PERIOD = 10;
  localparam int NPROG = 21;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        prog_we_i = 1'b0;
  logic [5:0]  prog_addr_i = '0;
  logic [31:0] prog_data_i = '0;
  logic [15:0] pc_o;
  logic [2:0]  phase_o;
  logic        wb_en_o;
  logic [4:0]  wb_addr_o;
  logic [15:0] wb_data_o;
  logic        st_en_o;
  logic [5:0]  st_addr_o;
  logic [15:0] st_data_o;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  risc16_core u_dut (.*);

  // instruction-level model state
  logic [31:0] prog    [NPROG];
  logic [15:0] m_reg   [32];
  logic [15:0] m_dmem  [64];
  logic [15:0] m_pc;
  logic        e_we, e_st;
  logic [4:0]  e_dst;
  logic [15:0] e_data, e_sdata, e_npc;
  logic [5:0]  e_saddr;
  string       e_req;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h (t=%0t)", req, act, exp, $time);
    end
  endtask

  function automatic logic [31:0] enc_r(int rs, int rt, int rd, int sh, logic [5:0] fn);
    return {6'h00, 5'(rs), 5'(rt), 5'(rd), 5'(sh), fn};
  endfunction
  function automatic logic [31:0] enc_i(logic [5:0] op, int rs, int rt, logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  function automatic logic [31:0] enc_j(logic [5:0] op, logic [25:0] t);
    return {op, t};
  endfunction

  // expected effect of the instruction at m_pc
  task automatic model_eval();
    logic [31:0] w;
    logic [5:0]  op, fn;
    logic [15:0] a, b, imm, ea, jad;
    logic [4:0]  sh;
    w   = prog[m_pc[6:2]];
    op  = w[31:26]; fn = w[5:0]; sh = w[10:6];
    a   = m_reg[w[25:21]]; b = m_reg[w[20:16]]; imm = w[15:0];
    ea  = a + imm;
    jad = {w[13:0], 2'b00};
    e_we = 0; e_st = 0; e_dst = w[20:16]; e_data = '0; e_sdata = '0; e_saddr = '0;
    e_npc = m_pc + 16'd4; e_req = "R12";
    case (op)
      6'h00: begin
        e_dst = w[15:11]; e_we = 1; e_req = "R3";
        case (fn)
          6'h20: e_data = a + b;
          6'h22: e_data = a - b;
          6'h24: e_data = a & b;
          6'h25: e_data = a | b;
          6'h26: e_data = a ^ b;
          6'h00: begin e_data = 16'(32'(a) << sh); e_req = "R4"; end
          6'h02: begin e_data = 16'(32'(a) >> sh); e_req = "R4"; end
          default: begin e_we = 0; e_req = "R12"; end
        endcase
      end
      6'h08: begin e_we = 1; e_data = ea; e_req = "R5"; end
      6'h23: begin e_we = 1; e_data = m_dmem[ea[5:0]]; e_req = "R6"; end
      6'h2B: begin e_st = 1; e_saddr = ea[5:0]; e_sdata = b; e_req = "R7"; end
      6'h02: begin e_npc = jad; e_req = "R10"; end
      6'h03: begin e_npc = m_pc + jad; e_req = "R11"; end
      default: ;
    endcase
    if (e_we && e_dst == 5'd0) e_req = "R8";
  endtask

  task automatic load_prog(input logic [15:0] va, input logic [15:0] vb, input int sh, input int k);
    prog[0]  = enc_i(6'h08, 0, 1, va);
    prog[1]  = enc_i(6'h08, 0, 2, vb);
    prog[2]  = enc_r(1, 2, 3, 0, 6'h20);
    prog[3]  = enc_r(1, 2, 4, 0, 6'h22);
    prog[4]  = enc_r(1, 2, 5, 0, 6'h24);
    prog[5]  = enc_r(1, 2, 6, 0, 6'h25);
    prog[6]  = enc_r(1, 2, 7, 0, 6'h26);
    prog[7]  = enc_r(1, 0, 8, sh, 6'h00);
    prog[8]  = enc_r(2, 0, 9, sh, 6'h02);
    prog[9]  = enc_i(6'h2B, 1, 3, 16'(k) - va);   // base r1, address k
    prog[10] = enc_i(6'h23, 0, 10, 16'(k));
    prog[11] = enc_r(10, 1, 11, 0, 6'h20);       // consumes the load at once
    prog[12] = enc_i(6'h08, 1, 0, 16'h0005);     // write to r0
    prog[13] = enc_r(0, 0, 12, 0, 6'h20);
    prog[14] = 32'hFC00_0000;                    // unknown opcode
    prog[15] = enc_j(6'h03, 26'd2);              // to 17
    prog[16] = enc_i(6'h08, 0, 13, 16'h1111);    // skipped
    prog[17] = enc_j(6'h02, 26'd19);             // to 19
    prog[18] = enc_i(6'h08, 0, 14, 16'h2222);    // skipped
    prog[19] = enc_i(6'h08, 15, 15, 16'hFFFF);
    prog[20] = enc_j(6'h03, 26'h3FF_FFFF);       // back to 19
    rst_ni = 1'b0;
    for (int i = 0; i < NPROG; i++) begin
      @(negedge clk_i);
      prog_we_i = 1'b1; prog_addr_i = 6'(i); prog_data_i = prog[i];
    end
    @(negedge clk_i);
    prog_we_i = 1'b0;
    // R1: reset state
    chk(pc_o == 16'd0, "R1", 32'(pc_o), 0);
    chk(phase_o == 3'd0, "R1", 32'(phase_o), 0);
    chk(!wb_en_o && !st_en_o, "R1", {wb_en_o, st_en_o}, 0);
    for (int i = 0; i < 32; i++) m_reg[i] = '0;
    m_pc = '0;
  endtask

  task automatic run(input int ncyc);
    rst_ni = 1'b1;
    for (int c = 0; c < ncyc; c++) begin
      chk(phase_o == 3'(c % 5), "R2", 32'(phase_o), 32'(c % 5));
      if (phase_o == 3'd3) begin
        model_eval();
        chk(pc_o == m_pc, "R9", 32'(pc_o), 32'(m_pc));
        chk(st_en_o == e_st, (e_st ? "R7" : "R13"), 32'(st_en_o), 32'(e_st));
        if (e_st) begin
          chk(st_addr_o == e_saddr, "R7", 32'(st_addr_o), 32'(e_saddr));
          chk(st_data_o == e_sdata, "R7", 32'(st_data_o), 32'(e_sdata));
        end
      end else begin
        chk(!st_en_o, "R13", 32'(st_en_o), 0);
      end
      if (phase_o == 3'd4) begin
        chk(wb_en_o == e_we, (e_we ? e_req : "R13"), 32'(wb_en_o), 32'(e_we));
        if (e_we) begin
          chk(wb_addr_o == e_dst, e_req, 32'(wb_addr_o), 32'(e_dst));
          chk(wb_data_o == e_data, e_req, 32'(wb_data_o), 32'(e_data));
          if (e_dst != 5'd0) m_reg[e_dst] = e_data;
        end
        if (e_st) m_dmem[e_saddr] = e_sdata;
        m_pc = e_npc;
      end else begin
        chk(!wb_en_o, "R13", 32'(wb_en_o), 0);
      end
      @(negedge clk_i);
    end
  endtask

  logic [15:0] vals [8];

  initial begin
    vals[0] = 16'h0000; vals[1] = 16'h0001; vals[2] = 16'h0002; vals[3] = 16'h7FFF;
    vals[4] = 16'h8000; vals[5] = 16'hFFFF; vals[6] = 16'h1234; vals[7] = 16'hA5C3;
    for (int ai = 0; ai < 8; ai++) begin
      for (int bi = 0; bi < 8; bi++) begin
        load_prog(vals[ai], vals[bi], (ai * 3 + bi) % 32, ai * 8 + bi);
        run(125);
      end
    end
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule